// File: doc/BRIEF.md
# Serial Receive Channel with Line Error Detection

This block is the receive half of a serial port that runs either in start/stop (asynchronous) framing or in clocked, character-synchronous framing. It samples the serial line on its own receive clock enable, builds each character least significant bit first into a holding register, and raises a ready flag for the host to collect the character. Character length is 5 to 8 bits, and an optional parity bit can follow it with an even or odd sense.

In asynchronous mode the clock enable pulses at 16 times the bit rate. The receiver looks for a falling edge and confirms the start bit again at mid-bit, so that short glitches are rejected. It then samples every data bit, the parity bit and the stop bit at their centres. It reports parity and framing errors, overrun, and a break condition. In synchronous mode the clock enable pulses once per bit. The receiver first hunts for character alignment, either by matching one or two programmed sync characters on the line or by waiting for an external strobe. It then assembles characters back to back and reports that synchronization was found.

Top module: `usart_rx_core`

## Requirements
- R1: In asynchronous mode a received character appears on `rx_data`, least significant bit first, with unused upper bits zero, and `rx_ready` goes high once the stop bit has been sampled.
- R2: A `rd_strobe` pulse clears `rx_ready` when no character completes in the same cycle.
- R3: A low level on the line that is gone by the mid-bit check of the start bit is ignored: no character is produced and reception of a following valid frame is unaffected.
- R4: With `par_en`=1 the received parity bit is checked. With `par_even`=1 the data bits and the parity bit together must hold an even number of ones, and with `par_even`=0 an odd number. A mismatch sets `parity_err`.
- R5: A stop bit sampled low sets `framing_err`, and the character is still delivered.
- R6: When a character completes while `rx_ready` is still high, `overrun_err` is set and the new character replaces the old one in `rx_data`.
- R7: `parity_err`, `framing_err` and `overrun_err` stay set until an `err_clr` pulse clears all three. `err_clr` does not change `rx_ready` or `rx_data`.
- R8: `break_det` goes high when two consecutive frames each have all data bits, any parity bit and the stop bit low. It does not go high after only one such frame, and it returns low once the line is seen high while the receiver is idle.
- R9: In synchronous mode with internal alignment and one sync character, `sync_found` rises when the last `len` received bits equal `sync_a`. Characters are then assembled from the very next bit, and `hunt_start` clears `sync_found`.
- R10: With `two_sync`=1 the character that follows a match of `sync_a` must equal `sync_b` before `sync_found` rises. Otherwise the hunt restarts.
- R11: With `ext_sync`=1, a high level on `sync_in` during the hunt sets `sync_found`, and the next bit becomes bit 0 of the first character.
- R12: `char_len` selects the character length as 5 + `char_len` bits (0→5 bits, 3→8 bits). Sync characters are compared over the same length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_tick | input | 1 | Sample enable: 16x bit rate in asynchronous mode, 1x in synchronous mode |
| rxd | input | 1 | Serial line |
| sync_mode | input | 1 | 0 = asynchronous, 1 = synchronous |
| char_len | input | 2 | Character length minus 5 |
| par_en | input | 1 | Parity bit present and checked |
| par_even | input | 1 | 1 = even parity, 0 = odd parity |
| ext_sync | input | 1 | Synchronous alignment from `sync_in` instead of pattern match |
| two_sync | input | 1 | Internal hunt needs two sync characters |
| sync_a | input | 8 | First sync character |
| sync_b | input | 8 | Second sync character |
| hunt_start | input | 1 | Restart the synchronous hunt and clear `sync_found` |
| sync_in | input | 1 | External alignment strobe |
| rd_strobe | input | 1 | Host has read `rx_data` |
| err_clr | input | 1 | Clear parity, framing and overrun flags |
| rx_data | output | 8 | Last received character |
| rx_ready | output | 1 | Character waiting to be read |
| parity_err | output | 1 | Sticky parity error |
| framing_err | output | 1 | Sticky framing error |
| overrun_err | output | 1 | Sticky overrun error |
| break_det | output | 1 | Break condition on the line |
| sync_found | output | 1 | Synchronous alignment achieved |

## Verification
The hardest case to reach is a break. After the first all-low frame the receiver restarts at once on a line that is still low, so the second frame begins half a bit early and the test has to span both frames. The bench holds the line low for twenty bit times. It checks that `break_det` is still low after the first frame and high after the second, and then releases the line and waits for a third, clean frame to end before it expects `break_det` to drop. The failed two-character hunt is reached by sending the first sync character followed by a wrong character, and then the correct pair.

// File: rtl/usart_rx_core.sv
module usart_rx_core #(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_tick,
  input  logic       rxd,
  input  logic       sync_mode,
  input  logic [1:0] char_len,
  input  logic       par_en,
  input  logic       par_even,
  input  logic       ext_sync,
  input  logic       two_sync,
  input  logic [7:0] sync_a,
  input  logic [7:0] sync_b,
  input  logic       hunt_start,
  input  logic       sync_in,
  input  logic       rd_strobe,
  input  logic       err_clr,
  output logic [7:0] rx_data,
  output logic       rx_ready,
  output logic       parity_err,
  output logic       framing_err,
  output logic       overrun_err,
  output logic       break_det,
  output logic       sync_found
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] MID  = CW'(OSR/2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_STOP, S_HUNT, S_SYNC2, S_SDATA} st_t;
  st_t state;

  logic [CW-1:0] cnt;
  logic [3:0]    bitn;
  logic [7:0]    shreg, hreg;
  logic          pbit, brk_pend;

  wire [3:0] len   = 4'd5 + {2'b00, char_len};
  wire [3:0] nbits = len + {3'b000, par_en};
  wire       lastb = (bitn == nbits - 4'd1);
  wire       is_db = (bitn < len);
  wire [7:0] mask  = 8'hFF >> (2'd3 - char_len);
  wire [7:0] nxt   = shreg | ({7'd0, rxd} << bitn);
  wire [7:0] hwin  = {rxd, hreg[7:1]} >> (2'd3 - char_len);
  wire       hmatch = (hwin == (sync_a & mask));

  wire done_a = rx_tick && state == S_STOP && cnt == LAST;
  wire done_s = rx_tick && state == S_SDATA && lastb;
  wire done   = done_a || done_s;
  wire [7:0] cdata = (done_s && !par_en) ? nxt : shreg;
  wire       cpar  = done_s ? rxd : pbit;
  wire       pe_hit = par_en && (^cdata ^ cpar ^ ~par_even);
  wire       zframe = done_a && !rxd && cdata == 8'd0 && !(par_en && pbit);

  wire hunt_hit = rx_tick && state == S_HUNT && (ext_sync ? sync_in : (hmatch && !two_sync));
  wire sync2_ok = rx_tick && state == S_SYNC2 && bitn == len - 4'd1 && nxt == (sync_b & mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt   <= '0;
      bitn  <= '0;
      shreg <= '0;
      hreg  <= '0;
      pbit  <= 1'b0;
    end else if (hunt_start && sync_mode) begin
      state <= S_HUNT;
      hreg  <= '0;
    end else if (rx_tick) begin
      cnt <= cnt + 1'b1;
      case (state)
        S_IDLE: begin
          cnt <= '0;
          if (sync_mode) begin
            state <= S_HUNT;
            hreg  <= '0;
          end else if (!rxd) state <= S_START;
        end
        S_START:
          if (cnt == MID) begin
            cnt   <= '0;
            bitn  <= '0;
            shreg <= '0;
            state <= rxd ? S_IDLE : S_DATA;
          end
        S_DATA:
          if (cnt == LAST) begin
            if (is_db) shreg <= nxt;
            else pbit <= rxd;
            bitn <= bitn + 4'd1;
            if (lastb) state <= S_STOP;
          end
        S_STOP:
          if (cnt == LAST) state <= S_IDLE;
        S_HUNT: begin
          hreg  <= {rxd, hreg[7:1]};
          bitn  <= '0;
          shreg <= '0;
          if (ext_sync ? sync_in : hmatch)
            state <= (two_sync && !ext_sync) ? S_SYNC2 : S_SDATA;
        end
        S_SYNC2: begin
          shreg <= nxt;
          bitn  <= bitn + 4'd1;
          if (bitn == len - 4'd1) begin
            bitn  <= '0;
            shreg <= '0;
            hreg  <= '0;
            state <= (nxt == (sync_b & mask)) ? S_SDATA : S_HUNT;
          end
        end
        S_SDATA: begin
          if (is_db) shreg <= nxt;
          bitn <= bitn + 4'd1;
          if (lastb) begin
            bitn  <= '0;
            shreg <= '0;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_data     <= '0;
      rx_ready    <= 1'b0;
      parity_err  <= 1'b0;
      framing_err <= 1'b0;
      overrun_err <= 1'b0;
      break_det   <= 1'b0;
      brk_pend    <= 1'b0;
      sync_found  <= 1'b0;
    end else begin
      if (done) rx_data <= cdata;

      if (done) rx_ready <= 1'b1;
      else if (rd_strobe) rx_ready <= 1'b0;

      if (done && rx_ready && !rd_strobe) overrun_err <= 1'b1;
      else if (err_clr) overrun_err <= 1'b0;

      if (done && pe_hit) parity_err <= 1'b1;
      else if (err_clr) parity_err <= 1'b0;

      if (done_a && !rxd) framing_err <= 1'b1;
      else if (err_clr) framing_err <= 1'b0;

      if (done_a) brk_pend <= zframe;
      if (zframe && brk_pend) break_det <= 1'b1;
      else if (rx_tick && state == S_IDLE && rxd) break_det <= 1'b0;

      if (hunt_start) sync_found <= 1'b0;
      else if (hunt_hit || sync2_ok) sync_found <= 1'b1;
    end
  end

  assert_ready_on_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> rx_ready);

  assert_read_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !done) |=> !rx_ready);

  assert_overrun_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rx_ready && !rd_strobe) |=> overrun_err);

  assert_flags_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_clr && (parity_err || framing_err || overrun_err)) |=>
      ($past(parity_err) -> parity_err) && ($past(framing_err) -> framing_err) &&
      ($past(overrun_err) -> overrun_err));

  assert_clear_works_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !done) |=> !parity_err && !framing_err && !overrun_err);

  assert_sync_only_sync_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_found) |-> sync_mode);
endmodule

// File: tb/usart_rx_core_bench.sv
module usart_rx_core_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n = 1'b0, rx_tick = 1'b1, rxd = 1'b1;
  logic       sync_mode = 1'b0, par_en = 1'b0, par_even = 1'b1;
  logic       ext_sync = 1'b0, two_sync = 1'b0, hunt_start = 1'b0, sync_in = 1'b0;
  logic       rd_strobe = 1'b0, err_clr = 1'b0;
  logic [1:0] char_len = 2'd3;
  logic [7:0] sync_a = 8'h16, sync_b = 8'h3C;
  logic [7:0] rx_data;
  logic       rx_ready, parity_err, framing_err, overrun_err, break_det, sync_found;

  int n_chk = 0, n_bad = 0;

  usart_rx_core u_usart_rx_core (
    .clk(clk), .rst_n(rst_n), .rx_tick(rx_tick), .rxd(rxd), .sync_mode(sync_mode),
    .char_len(char_len), .par_en(par_en), .par_even(par_even), .ext_sync(ext_sync),
    .two_sync(two_sync), .sync_a(sync_a), .sync_b(sync_b), .hunt_start(hunt_start),
    .sync_in(sync_in), .rd_strobe(rd_strobe), .err_clr(err_clr), .rx_data(rx_data),
    .rx_ready(rx_ready), .parity_err(parity_err), .framing_err(framing_err),
    .overrun_err(overrun_err), .break_det(break_det), .sync_found(sync_found));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; rxd = 1'b1; sync_in = 1'b0; rd_strobe = 1'b0;
    err_clr = 1'b0; hunt_start = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic bits(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1; @(negedge clk); s = 1'b0;
  endtask

  task automatic frame(input logic [7:0] d, input int len, input logic pon,
                       input logic pb, input logic stp);
    rxd = 1'b0; bits(16);
    for (int i = 0; i < len; i++) begin rxd = d[i]; bits(16); end
    if (pon) begin rxd = pb; bits(16); end
    rxd = stp; bits(16);
    rxd = 1'b1; bits(4);
  endtask

  task automatic sbits(input logic [7:0] v, input int n);
    for (int i = 0; i < n; i++) begin rxd = v[i]; @(negedge clk); end
  endtask

  task automatic t_reset();
    sync_mode = 0; char_len = 2'd3; par_en = 0;
    do_reset();
    chk("R1 reset ready", {7'd0, rx_ready}, 8'd0);
    chk("R7 reset flags", {5'd0, parity_err, framing_err, overrun_err}, 8'd0);
    chk("R8 reset break", {7'd0, break_det}, 8'd0);
  endtask

  task automatic t_basic();
    sync_mode = 0; char_len = 2'd3; par_en = 0;
    do_reset();
    frame(8'hA5, 8, 0, 0, 1);
    chk("R1 data", rx_data, 8'hA5);
    chk("R1 ready", {7'd0, rx_ready}, 8'd1);
    pulse(rd_strobe);
    chk("R2 read clears ready", {7'd0, rx_ready}, 8'd0);
    frame(8'h3C, 8, 0, 0, 1);
    chk("R1 second data", rx_data, 8'h3C);
    chk("R6 no overrun after read", {7'd0, overrun_err}, 8'd0);
  endtask

  task automatic t_glitch();
    sync_mode = 0; char_len = 2'd3; par_en = 0;
    do_reset();
    rxd = 1'b0; bits(4); rxd = 1'b1; bits(200);
    chk("R3 glitch ignored", {7'd0, rx_ready}, 8'd0);
    frame(8'h81, 8, 0, 0, 1);
    chk("R3 frame after glitch", rx_data, 8'h81);
  endtask

  task automatic t_parity();
    sync_mode = 0; char_len = 2'd3; par_en = 1; par_even = 1;
    do_reset();
    frame(8'h35, 8, 1, 0, 1);
    chk("R4 even good", {7'd0, parity_err}, 8'd0);
    pulse(rd_strobe);
    frame(8'h35, 8, 1, 1, 1);
    chk("R4 even bad", {7'd0, parity_err}, 8'd1);
    par_even = 0;
    do_reset();
    frame(8'h07, 8, 1, 0, 1);
    chk("R4 odd good", {7'd0, parity_err}, 8'd0);
    pulse(rd_strobe);
    frame(8'h07, 8, 1, 1, 1);
    chk("R4 odd bad", {7'd0, parity_err}, 8'd1);
    chk("R4 data kept", rx_data, 8'h07);
    par_en = 0;
  endtask

  task automatic t_frame_err();
    sync_mode = 0; char_len = 2'd3; par_en = 0;
    do_reset();
    frame(8'h5A, 8, 0, 0, 0);
    chk("R5 framing set", {7'd0, framing_err}, 8'd1);
    chk("R5 data delivered", rx_data, 8'h5A);
    pulse(rd_strobe);
    frame(8'h11, 8, 0, 0, 1);
    chk("R7 framing sticky", {7'd0, framing_err}, 8'd1);
  endtask

  task automatic t_overrun();
    sync_mode = 0; char_len = 2'd3; par_en = 0;
    do_reset();
    frame(8'h12, 8, 0, 0, 1);
    frame(8'h34, 8, 0, 0, 1);
    chk("R6 overrun set", {7'd0, overrun_err}, 8'd1);
    chk("R6 data replaced", rx_data, 8'h34);
    pulse(err_clr);
    chk("R7 clear flags", {5'd0, parity_err, framing_err, overrun_err}, 8'd0);
    chk("R7 clear keeps ready", {7'd0, rx_ready}, 8'd1);
    chk("R7 clear keeps data", rx_data, 8'h34);
  endtask

  task automatic t_break();
    sync_mode = 0; char_len = 2'd3; par_en = 0;
    do_reset();
    rxd = 1'b0; bits(170);
    chk("R8 one frame no break", {7'd0, break_det}, 8'd0);
    chk("R5 break frame framing", {7'd0, framing_err}, 8'd1);
    bits(150);
    chk("R8 break after two frames", {7'd0, break_det}, 8'd1);
    rxd = 1'b1; bits(200);
    chk("R8 break clears", {7'd0, break_det}, 8'd0);
  endtask

  task automatic t_len5();
    sync_mode = 0; char_len = 2'd0; par_en = 0;
    do_reset();
    frame(8'h1F, 5, 0, 0, 1);
    chk("R12 five-bit data", rx_data, 8'h1F);
    chk("R12 five-bit no framing", {7'd0, framing_err}, 8'd0);
    pulse(rd_strobe);
    frame(8'h15, 5, 0, 0, 1);
    chk("R12 five-bit second", rx_data, 8'h15);
    char_len = 2'd3;
  endtask

  task automatic t_hunt1();
    sync_mode = 1; ext_sync = 0; two_sync = 0; char_len = 2'd3; par_en = 0;
    do_reset();
    bits(5);
    chk("R9 no sync yet", {7'd0, sync_found}, 8'd0);
    sbits(8'h16, 8);
    chk("R9 sync found", {7'd0, sync_found}, 8'd1);
    sbits(8'hC3, 8);
    chk("R9 char after sync", rx_data, 8'hC3);
    chk("R9 ready", {7'd0, rx_ready}, 8'd1);
    rxd = 1'b1;
    pulse(hunt_start);
    chk("R9 hunt restart clears", {7'd0, sync_found}, 8'd0);
  endtask

  task automatic t_hunt2();
    sync_mode = 1; ext_sync = 0; two_sync = 1; char_len = 2'd3; par_en = 0;
    do_reset();
    bits(3);
    sbits(8'h16, 8);
    sbits(8'h55, 8);
    chk("R10 wrong second char", {7'd0, sync_found}, 8'd0);
    sbits(8'h16, 8);
    chk("R10 first alone", {7'd0, sync_found}, 8'd0);
    sbits(8'h3C, 8);
    chk("R10 pair found", {7'd0, sync_found}, 8'd1);
    sbits(8'h9E, 8);
    chk("R10 char after pair", rx_data, 8'h9E);
    two_sync = 0;
  endtask

  task automatic t_ext();
    sync_mode = 1; ext_sync = 1; two_sync = 0; char_len = 2'd3; par_en = 0;
    do_reset();
    rxd = 1'b0; sbits(8'h16, 8);
    chk("R11 no pattern sync", {7'd0, sync_found}, 8'd0);
    pulse(sync_in);
    chk("R11 strobe sync", {7'd0, sync_found}, 8'd1);
    sbits(8'h5A, 8);
    chk("R11 first char", rx_data, 8'h5A);
    ext_sync = 0;
  endtask

  task automatic t_sync_len6();
    sync_mode = 1; ext_sync = 0; two_sync = 0; char_len = 2'd1; par_en = 0;
    sync_a = 8'h16;
    do_reset();
    bits(3);
    sbits(8'h16, 6);
    chk("R12 six-bit sync", {7'd0, sync_found}, 8'd1);
    sbits(8'h2B, 6);
    chk("R12 six-bit char", rx_data, 8'h2B);
    char_len = 2'd3;
  endtask

  initial begin
    fork
      begin
        t_reset(); t_basic(); t_glitch(); t_parity(); t_frame_err();
        t_overrun(); t_break(); t_len5(); t_hunt1(); t_hunt2(); t_ext(); t_sync_len6();
      end
      begin
        repeat (150000) @(negedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule